// File: doc/BRIEF.md
# Mapper-Aware DMA Bus Master

This block is a single-channel DMA engine for a Z80-style system bus. When an attached device asks for data, the engine takes the bus from the CPU. It points the memory mapper at the right segment and reads one or more bytes, handing each byte to the device. It then puts the mapper segment back the way the CPU left it and returns the bus. The block keeps a 24-bit byte pointer. Bits 13..0 address a byte inside a fixed 16 KiB page. The implemented part of the upper bits names a mapper segment. The pointer is advanced after every byte.

The CPU programs the pointer and an enable bit through four write registers and reads one status byte. The block also watches the CPU's own I/O writes to the mapper port. That lets it restore the segment the CPU last selected. Whenever the low 14 pointer bits wrap during a burst, the new segment is written before the next read.

The device side is a valid/ready stream without a length. `dev_ready` high means the device wants a byte. `dev_valid` is a one-clock beat that carries `dev_data`, and the device must take it. Back-pressure works by lowering `dev_ready`. The engine samples `dev_ready` in the clock after each beat. A device that wants no more bytes must have `dev_ready` low by then. Otherwise the engine starts another read in the same bus tenure.

Top module: `dma_mapper_master`

## Requirements
- R1: With enable set and the engine idle, `dev_ready` high causes `busreq_n` to go low at the next clock edge. No bus strobe is driven until `busack_n` is low.
- R2: With enable clear (write register 3, bit 0 = 0), `dev_ready` is ignored: `busreq_n` stays high and status stays 00h.
- R3: The first bus cycle of a tenure is an I/O write to port `{6'b111111, PAGE}` (FEh with the default PAGE of 2). Its data is pointer bits [14 +: SEG_BITS], zero-extended to 8 bits, so pointer bits above the segment field are written as zero.
- R4: Each memory read drives address `{PAGE, pointer[13:0]}`. It holds `mreq_n` and `rd_n` low for 3 clocks, plus one clock for every clock `wait_n` is sampled low in T2.
- R5: Each I/O write holds `iorq_n` and `wr_n` low for 3 clocks (T2, the automatic wait state, T3), so the cycle is 4 clocks counting T1. It gains one clock for every clock `wait_n` is sampled low in the wait state. `wr_n` is never low outside an I/O cycle.
- R6: In T3 of each memory read, `dev_valid` is high for exactly one clock and `dev_data` equals `bus_din`. The pointer then advances by one.
- R7: If `dev_ready` is still high in the clock after a beat, the engine starts the next read without releasing `busreq_n`.
- R8: If the byte just read sat at offset 3FFFh, a segment I/O write with the incremented pointer's segment comes before the next read in the same tenure.
- R9: After the last read, the engine performs an I/O write to the same port carrying the last byte the CPU wrote to that port, taken from the snoop inputs. Snooped writes to other ports are ignored. After reset the value is 02h.
- R10: After the restore write, `busreq_n` goes high. Status is `{6'b0, busy, enable}`. Busy is high from the clock `busreq_n` falls until the clock after `busack_n` is seen high again, and it is high whenever `busreq_n` is low.
- R11: Write registers 0, 1 and 2 hold pointer bits 7..0, 15..8 and 23..16. Register 3 bit 0 is enable. Pointer writes arriving while busy are dropped.
- R12: `mreq_n` and `iorq_n` are never low together, and neither is low unless `busreq_n` and `busack_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | CPU register select |
| cpu_wdata | input | 8 | CPU register write data |
| cpu_rdata | output | 8 | Status: bit 1 busy, bit 0 enable |
| snoop_we | input | 1 | A CPU I/O write is on the bus this clock |
| snoop_port | input | 8 | Port of the observed CPU I/O write |
| snoop_data | input | 8 | Data of the observed CPU I/O write |
| busreq_n | output | 1 | Bus request, active low |
| busack_n | input | 1 | Bus grant, active low |
| wait_n | input | 1 | Wait request from memory or I/O, active low |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data driven during I/O writes |
| bus_din | input | 8 | Data returned by memory |
| dev_ready | input | 1 | Device wants a byte |
| dev_valid | output | 1 | One-clock data beat to the device |
| dev_data | output | 8 | Byte handed to the device |

## Verification
The main burst path is swept over start offsets 0000h, 1234h, 3FFEh and 3FFFh, burst lengths of one to three bytes, zero to two wait clocks per bus cycle and zero to two clocks of grant delay. The offsets split bursts that never carry from those that carry on the first or second byte, which separates the segment reload from the plain loop. The wait and grant sweeps show that strobe lengths and the request/grant handshake stretch exactly as far as the inputs demand. Snooped writes to the mapper port change between bursts, and writes to a neighbouring port are interleaved. This tells a correct restore value apart from a stale one, from the reset value, or from one captured on the wrong port. A pointer write issued mid-burst shows whether busy-time writes are really dropped.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int PTR_W = 24;
  localparam int OFS_W = 14;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_SEG, S_SEGW, S_RD, S_RDW, S_DEC, S_RST, S_RSTW, S_REL
  } seq_state_t;

  typedef enum logic [2:0] {
    C_IDLE, C_T1, C_T2, C_TW, C_T3
  } cyc_state_t;
endpackage

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
  import dma_pkg::*;
#(
  parameter int SEG_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [1:0]       cpu_addr,
  input  logic [7:0]       cpu_wdata,
  input  logic             busy,
  input  logic             inc,
  output logic [OFS_W-1:0] ofs,
  output logic [7:0]       seg,
  output logic             en
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      en    <= 1'b0;
    end else begin
      if (inc) begin
        ptr_q <= ptr_q + 1'b1;
      end else if (cpu_we && !busy && cpu_addr != 2'd3) begin
        ptr_q[cpu_addr*8 +: 8] <= cpu_wdata;
      end
      if (cpu_we && cpu_addr == 2'd3) begin
        en <= cpu_wdata[0];
      end
    end
  end

  // Segment field zero-extended; pointer bits above it never reach the mapper.
  always_comb begin
    seg = '0;
    seg[SEG_BITS-1:0] = ptr_q[OFS_W +: SEG_BITS];
  end

  assign ofs = ptr_q[OFS_W-1:0];
endmodule

// File: rtl/dma_map_snoop.sv
module dma_map_snoop #(
  parameter logic [7:0] PORT      = 8'hFE,
  parameter logic [7:0] RESET_VAL = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snoop_we,
  input  logic [7:0] snoop_port,
  input  logic [7:0] snoop_data,
  output logic [7:0] restore_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restore_val <= RESET_VAL;
    end else if (snoop_we && snoop_port == PORT) begin
      restore_val <= snoop_data;
    end
  end
endmodule

// File: rtl/dma_bus_cycle.sv
module dma_bus_cycle
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_io,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wait_n,
  input  logic [7:0]  bus_din,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_dout,
  output logic        mreq_n,
  output logic        iorq_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic        done,
  output logic        beat_valid,
  output logic [7:0]  beat_data
);
  cyc_state_t st;
  logic        io_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= C_IDLE;
      io_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st)
        C_IDLE: if (start) begin
          st     <= C_T1;
          io_q   <= is_io;
          addr_q <= addr;
          data_q <= wdata;
        end
        C_T1:   st <= C_T2;
        C_T2: begin
          if (io_q)        st <= C_TW;
          else if (wait_n) st <= C_T3;
        end
        C_TW:   if (wait_n) st <= C_T3;
        C_T3:   st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  logic active, io_strobe, mem_strobe;
  assign active     = (st != C_IDLE);
  assign mem_strobe = active && !io_q;
  assign io_strobe  = io_q && (st == C_T2 || st == C_TW || st == C_T3);

  assign mreq_n     = !mem_strobe;
  assign rd_n       = !mem_strobe;
  assign iorq_n     = !io_strobe;
  assign wr_n       = !io_strobe;
  assign bus_addr   = active ? addr_q : 16'h0000;
  assign bus_dout   = (active && io_q) ? data_q : 8'h00;
  assign done       = (st == C_T3);
  assign beat_valid = (st == C_T3) && !io_q;
  assign beat_data  = bus_din;
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
#(
  parameter logic [1:0] PAGE = 2'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dev_ready,
  input  logic             busack_n,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       seg,
  input  logic [7:0]       restore_val,
  input  logic             cyc_done,
  output logic             busreq_n,
  output logic             busy,
  output logic             inc,
  output logic             cyc_start,
  output logic             cyc_io,
  output logic [15:0]      cyc_addr,
  output logic [7:0]       cyc_wdata
);
  localparam logic [7:0] MAP_PORT = {6'b111111, PAGE};

  seq_state_t st;
  logic       carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      carry_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (en && dev_ready) st <= S_REQ;
        S_REQ:  if (!busack_n)       st <= S_SEG;
        S_SEG:  st <= S_SEGW;
        S_SEGW: if (cyc_done)        st <= S_RD;
        S_RD:   st <= S_RDW;
        S_RDW: if (cyc_done) begin
          carry_q <= &ofs;
          st      <= S_DEC;
        end
        S_DEC: begin
          if (en && dev_ready) st <= carry_q ? S_SEG : S_RD;
          else                 st <= S_RST;
        end
        S_RST:  st <= S_RSTW;
        S_RSTW: if (cyc_done)        st <= S_REL;
        S_REL:  if (busack_n)        st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busreq_n  = (st == S_IDLE) || (st == S_REL);
  assign busy      = (st != S_IDLE);
  assign inc       = (st == S_RDW) && cyc_done;
  assign cyc_start = (st == S_SEG) || (st == S_RD) || (st == S_RST);
  assign cyc_io    = (st != S_RD);
  assign cyc_addr  = (st == S_RD) ? {PAGE, ofs} : {8'h00, MAP_PORT};
  assign cyc_wdata = (st == S_RST) ? restore_val : seg;
endmodule

// File: rtl/dma_mapper_master.sv
module dma_mapper_master
  import dma_pkg::*;
#(
  parameter logic [1:0] PAGE        = 2'd2,
  parameter int         SEG_BITS    = 6,
  parameter logic [7:0] SNOOP_RESET = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        snoop_we,
  input  logic [7:0]  snoop_port,
  input  logic [7:0]  snoop_data,
  output logic        busreq_n,
  input  logic        busack_n,
  input  logic        wait_n,
  output logic        mreq_n,
  output logic        iorq_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_dout,
  input  logic [7:0]  bus_din,
  input  logic        dev_ready,
  output logic        dev_valid,
  output logic [7:0]  dev_data
);
  localparam logic [7:0] MAP_PORT = {6'b111111, PAGE};

  logic             busy, inc, en;
  logic [OFS_W-1:0] ofs;
  logic [7:0]       seg, restore_val;
  logic             cyc_start, cyc_io, cyc_done;
  logic [15:0]      cyc_addr;
  logic [7:0]       cyc_wdata;

  dma_ptr_regs #(.SEG_BITS(SEG_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .busy(busy), .inc(inc), .ofs(ofs), .seg(seg), .en(en)
  );

  dma_map_snoop #(.PORT(MAP_PORT), .RESET_VAL(SNOOP_RESET)) u_snoop (
    .clk(clk), .rst_n(rst_n), .snoop_we(snoop_we), .snoop_port(snoop_port),
    .snoop_data(snoop_data), .restore_val(restore_val)
  );

  dma_sequencer #(.PAGE(PAGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .dev_ready(dev_ready), .busack_n(busack_n),
    .ofs(ofs), .seg(seg), .restore_val(restore_val), .cyc_done(cyc_done),
    .busreq_n(busreq_n), .busy(busy), .inc(inc), .cyc_start(cyc_start),
    .cyc_io(cyc_io), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata)
  );

  dma_bus_cycle u_cyc (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .is_io(cyc_io), .addr(cyc_addr),
    .wdata(cyc_wdata), .wait_n(wait_n), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .done(cyc_done), .beat_valid(dev_valid), .beat_data(dev_data)
  );

  assign cpu_rdata = {6'b000000, busy, en};
endmodule

// File: rtl/dma_mapper_master_chk.sv
module dma_mapper_master_chk #(
  parameter logic [1:0] PAGE = 2'd2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busreq_n,
  input logic        busack_n,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [15:0] bus_addr,
  input logic        dev_valid,
  input logic [7:0]  cpu_rdata
);
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n || !iorq_n) |-> (!busreq_n && !busack_n)); // R12
  AST_ONE_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n)); // R12
  AST_MAP_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> (bus_addr[7:0] == {6'b111111, PAGE})); // R3
  AST_READ_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq_n |-> (bus_addr[15:14] == PAGE && !rd_n)); // R4
  AST_WRITE_IS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !iorq_n); // R5
  AST_BEAT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> (!mreq_n && !rd_n)); // R6
  AST_BEAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |=> !dev_valid); // R6
  AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busreq_n |-> cpu_rdata[1]); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdata[0] && !cpu_rdata[1]) |=> busreq_n); // R2
endmodule

bind dma_mapper_master dma_mapper_master_chk #(.PAGE(PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .busack_n(busack_n),
  .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
  .bus_addr(bus_addr), .dev_valid(dev_valid), .cpu_rdata(cpu_rdata)
);

// File: tb/dma_mapper_master_tb.sv
module dma_mapper_master_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = 2'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        snoop_we = 1'b0;
  logic [7:0]  snoop_port = 8'h00;
  logic [7:0]  snoop_data = 8'h00;
  logic        busreq_n, mreq_n, iorq_n, rd_n, wr_n, dev_valid;
  logic        busack_n = 1'b1;
  logic        wait_n = 1'b1;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout, bus_din, dev_data;
  logic        dev_ready;

  dma_mapper_master u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .snoop_we(snoop_we),
    .snoop_port(snoop_port), .snoop_data(snoop_data), .busreq_n(busreq_n),
    .busack_n(busack_n), .wait_n(wait_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .dev_ready(dev_ready), .dev_valid(dev_valid), .dev_data(dev_data)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: byte depends on page offset and the mapper segment selected.
  function automatic logic [7:0] memf(input logic [13:0] a, input logic [7:0] s);
    return a[7:0] ^ {a[13:8], 2'b00} ^ 8'(s * 8'd37);
  endfunction

  function automatic logic [7:0] segf(input logic [23:0] p);
    return {2'b00, p[19:14]};
  endfunction

  logic [7:0] map_seg = 8'h00;
  assign bus_din = memf(bus_addr[13:0], map_seg);

  // Expected bus events and bytes.
  int          ek [512];
  logic [15:0] ev [512];
  string       ereq [512];
  logic [7:0]  exp_byte [512];
  int n_exp = 0, i_exp = 0, nb = 0;
  int beats_total = 0, target = 0;
  bit dev_on = 1'b0;
  int wait_w = 0, arb_d = 0;
  int req_falls = 0;

  assign dev_ready = dev_on && (beats_total < target);

  int  acnt = 0, wcnt = 0, cnt_m = 0, cnt_i = 0;
  bit  prev_m = 1'b1, prev_i = 1'b1, prev_rq = 1'b1, mstart, istart;

  always @(negedge clk) begin
    if (rst_n) begin
      mstart = !mreq_n && prev_m;
      istart = !iorq_n && prev_i;
      if (!busreq_n && prev_rq) req_falls++;
      if (mstart || istart) chk(!busack_n && !busreq_n, "R12", busack_n, 0);
      if (mstart) begin
        if (i_exp >= n_exp) chk(1'b0, "R7", i_exp, n_exp);
        else begin
          chk(ek[i_exp] == 1, ereq[i_exp], 0, 1);
          chk(bus_addr == ev[i_exp], ereq[i_exp], bus_addr, ev[i_exp]);
          i_exp++;
        end
      end
      if (istart) begin
        chk(bus_addr[7:0] == 8'hFE, "R3", bus_addr[7:0], 8'hFE);
        if (i_exp >= n_exp) chk(1'b0, "R9", i_exp, n_exp);
        else begin
          chk(ek[i_exp] == 0, ereq[i_exp], 1, 0);
          chk(bus_dout == ev[i_exp][7:0], ereq[i_exp], bus_dout, ev[i_exp][7:0]);
          i_exp++;
        end
        map_seg = bus_dout;
      end
      if (!mreq_n) cnt_m++;
      else if (!prev_m) begin chk(cnt_m == 3 + wait_w, "R4", cnt_m, 3 + wait_w); cnt_m = 0; end
      if (!iorq_n) cnt_i++;
      else if (!prev_i) begin chk(cnt_i == 3 + wait_w, "R5", cnt_i, 3 + wait_w); cnt_i = 0; end
      if (dev_valid) begin
        chk(dev_data == exp_byte[beats_total], "R6", dev_data, exp_byte[beats_total]);
        beats_total++;
      end
      if (mstart || istart) wcnt = wait_w + 1;
      else if (wcnt > 0) wcnt--;
      wait_n = (wcnt == 0);
      if (busreq_n != busack_n) begin
        if (acnt >= arb_d) begin busack_n = busreq_n; acnt = 0; end
        else acnt++;
      end else acnt = 0;
      prev_m = mreq_n; prev_i = iorq_n; prev_rq = busreq_n;
    end
  end

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic snoop(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk); snoop_we = 1'b1; snoop_port = port; snoop_data = d;
    @(negedge clk); snoop_we = 1'b0;
  endtask

  task automatic push(input int k, input logic [15:0] v, input string r);
    ek[n_exp] = k; ev[n_exp] = v; ereq[n_exp] = r; n_exp++;
  endtask

  task automatic prep(input logic [23:0] p, input int len, input int w, input int d,
                      input logic [7:0] rv, input bit setp);
    logic [23:0] q;
    if (setp) begin
      cpu_write(2'd0, p[7:0]); cpu_write(2'd1, p[15:8]); cpu_write(2'd2, p[23:16]);
    end
    wait_w = w; arb_d = d;
    q = p;
    for (int i = 0; i < len; i++) begin
      if (i == 0) push(0, {8'h00, segf(q)}, "R3");
      else if (q[13:0] == 14'h0000) push(0, {8'h00, segf(q)}, "R8");
      push(1, {2'b10, q[13:0]}, "R4");
      exp_byte[nb] = memf(q[13:0], segf(q)); nb++;
      q = q + 24'd1;
    end
    push(0, {8'h00, rv}, "R9");
    target = beats_total + len;
    req_falls = 0;
  endtask

  task automatic finish_burst();
    bit saw_busy = 1'b0;
    int t = 0;
    while (!((beats_total >= target) && !cpu_rdata[1]) && t < 2000) begin
      if (cpu_rdata[1]) saw_busy = 1'b1;
      @(negedge clk); t++;
    end
    dev_on = 1'b0;
    chk(t < 2000, "R7", t, 2000);
    chk(saw_busy, "R10", saw_busy, 1);
    chk(i_exp == n_exp, "R9", i_exp, n_exp);
    chk(req_falls == 1, "R7", req_falls, 1);
    chk(cpu_rdata == 8'h01, "R10", cpu_rdata, 8'h01);
    chk(busreq_n == 1'b1, "R10", busreq_n, 1);
  endtask

  task automatic burst(input logic [23:0] p, input int len, input int w, input int d,
                       input logic [7:0] rv, input bit setp, input bit poke);
    prep(p, len, w, d, rv, setp);
    dev_on = 1'b1;
    if (poke) begin
      while (!cpu_rdata[1]) @(negedge clk);
      cpu_write(2'd0, 8'hAA); // R11: dropped while busy
    end
    finish_burst();
  endtask

  initial begin
    #1_500_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  rv;
    logic [23:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rdata == 8'h00, "R10", cpu_rdata, 0);
    chk(busreq_n == 1'b1, "R1", busreq_n, 1);
    chk(mreq_n && iorq_n && rd_n && wr_n, "R12", {mreq_n, iorq_n, rd_n, wr_n}, 4'hF);
    chk(dev_valid == 1'b0, "R6", dev_valid, 0);

    // R2: disabled engine ignores the device, then R1 on enable; restore is reset value (R9).
    prep(24'hC5_3FFE, 3, 0, 1, 8'h02, 1'b1);
    dev_on = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!busreq_n || cpu_rdata != 8'h00) quiet = 1'b0;
      end
      chk(quiet, "R2", quiet, 1);
    end
    cpu_write(2'd3, 8'h01);
    chk(busreq_n == 1'b1, "R1", busreq_n, 1);
    @(negedge clk);
    chk(busreq_n == 1'b0, "R1", busreq_n, 0);
    finish_burst();

    rv = 8'h02;
    for (int o = 0; o < 4; o++) begin
      for (int len = 1; len <= 3; len++) begin
        for (int w = 0; w <= 2; w++) begin
          logic [13:0] lo;
          logic [9:0]  hi;
          lo = (o == 0) ? 14'h0000 : (o == 1) ? 14'h1234 : (o == 2) ? 14'h3FFE : 14'h3FFF;
          hi = 10'(o * 97 + len * 13 + w * 5);
          if (w == 1) snoop(8'hFD, 8'h77); // R9: other port ignored
          if (((o + len + w) % 2) == 0) begin
            rv = 8'(o * 16 + len * 4 + w + 8'h40);
            snoop(8'hFE, rv);
          end
          burst({hi, lo}, len, w, (len + w) % 3, rv, 1'b1, 1'b0);
        end
      end
    end

    // R11: pointer write during a burst is dropped; next burst continues from the pointer.
    burst(24'h01_2345, 3, 1, 0, rv, 1'b1, 1'b1);
    burst(24'h01_2348, 2, 0, 2, rv, 1'b0, 1'b0);
    // R11: register 3 clears enable and the engine stays quiet.
    cpu_write(2'd3, 8'h00);
    chk(cpu_rdata == 8'h00, "R11", cpu_rdata, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule